// File: doc/BRIEF.md
# Microcode Upload and Verify Sequencer

This block is a master-side sequencer that installs a byte-wide program image into the SRAM of an embedded processor that sits behind a 32-bit register window. First it parks the processor. Then it rewinds the SRAM pointer and writes the image one byte per register access. It rewinds the pointer a second time and reads the whole image back, comparing each byte. Only when that comparison is clean does it write the control word that releases the processor.

All traffic leaves through one register-access port with a request/acknowledge handshake. The request and its fields stay steady until the cycle in which `acc_ack` is high. The cycle after an acknowledge may already carry the next request. Image bytes come from a local store that is read combinationally: the block drives `img_idx` and takes `img_byte` in the same cycle. When a run ends, `done` rises and stays high until the next `go`. At that point `pass`, `miss_cnt` and `first_miss` give the outcome.

Top module: `ucode_loader`

## Requirements
- R1: After reset, `done`, `pass`, `busy` and `acc_req` are 0, and `miss_cnt` and `first_miss` are 0.
- R2: A run opens with a write of 0x08C to register 0x10. This word sets bits 7, 3 and 2: hold the processor in reset, enable boot, and enable external access.
- R3: The next access writes 0x00000000 to register 0x11, which rewinds the SRAM pointer.
- R4: Image bytes 0 to `img_len`-1 then go out in index order as writes to register 0x12, one access per byte, each byte zero-extended into `acc_wdata[7:0]`.
- R5: After the last byte, register 0x11 is written with 0 again. Register 0x12 is then read once per byte, in index order.
- R6: A readback with any bit above bit 7 set ends the run at once with `done`=1 and `pass`=0. No further access is made.
- R7: A readback whose low byte differs from the image byte adds one to `miss_cnt`. `first_miss` holds the index of the first such byte, and reads 0 when there is none.
- R8: Once the fifth mismatch is seen, reading stops and the run fails. `miss_cnt` never exceeds 5.
- R9: A run that ends with a nonzero `miss_cnt` fails, and the start word is never written.
- R10: A clean readback is followed by a write of 0x10B to register 0x10. This word sets bits 8, 3, 1 and 0: clock divide, boot enable, clock enable and soft reset. After that write, `done`=1 and `pass`=1.
- R11: An acknowledge with `acc_err`=1 ends the run at once as a failure, and the counters are not updated by that access.
- R12: When `img_len`=0, the run is hold, rewind, rewind, start, and it passes.
- R13: While `acc_req` is high and `acc_ack` is low, `acc_we`, `acc_addr` and `acc_wdata` hold their values.
- R14: A `go` pulse during a run is ignored. The run in progress keeps its length and sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts a run when idle; `img_len` is captured at the same edge |
| img_len | input | LEN_W | Number of image bytes |
| img_idx | output | LEN_W | Index of the image byte wanted |
| img_byte | input | 8 | Image byte at `img_idx`, valid in the same cycle |
| acc_req | output | 1 | Register access request |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | REG_AW | Register address |
| acc_wdata | output | REG_DW | Write data |
| acc_ack | input | 1 | Access completes in this cycle |
| acc_err | input | 1 | Error response, valid with `acc_ack` |
| acc_rdata | input | REG_DW | Read data, valid with `acc_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended |
| pass | output | 1 | The last run installed and started the image |
| miss_cnt | output | MW | Readback mismatches counted |
| first_miss | output | LEN_W | Index of the first mismatching byte |

## Verification
Two pairs of events are made to land on a single acknowledge.

The first pair is the limit-crossing mismatch and the end of the read pass. A 5-byte image is corrupted on every readback, so the fifth mismatch arrives on the last byte. The expected result is a fail with `miss_cnt`=5, exactly 13 accesses, and no start write.

The second pair is an error response and a mismatching byte. The second read of a fully corrupted image is given an error response. That ack must abort the run while `miss_cnt` stays at 1, the count reached by the first read alone.

// File: rtl/ucode_loader.sv
module ucode_loader #(
  parameter int LEN_W      = 12,
  parameter int MISS_LIMIT = 4,
  parameter int REG_AW     = 8,
  parameter int REG_DW     = 32,
  parameter logic [REG_AW-1:0] CTRL_REG  = 8'h10,
  parameter logic [REG_AW-1:0] PTR_REG   = 8'h11,
  parameter logic [REG_AW-1:0] DATA_REG  = 8'h12,
  parameter logic [REG_DW-1:0] HOLD_WORD = 32'h0000_008C,
  parameter logic [REG_DW-1:0] RUN_WORD  = 32'h0000_010B,
  localparam int MW = $clog2(MISS_LIMIT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  img_len,
  output logic [LEN_W-1:0]  img_idx,
  input  logic [7:0]        img_byte,
  output logic              acc_req,
  output logic              acc_we,
  output logic [REG_AW-1:0] acc_addr,
  output logic [REG_DW-1:0] acc_wdata,
  input  logic              acc_ack,
  input  logic              acc_err,
  input  logic [REG_DW-1:0] acc_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [MW-1:0]     miss_cnt,
  output logic [LEN_W-1:0]  first_miss
);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_REW1, S_LOAD, S_REW2, S_CHECK, S_RUN} st_t;

  st_t              st;
  logic [LEN_W-1:0] idx, len_q;
  logic             last, rd_big, rd_bad;

  assign busy    = (st != S_IDLE);
  assign acc_req = busy;
  assign acc_we  = (st != S_CHECK);
  assign img_idx = idx;
  assign last    = (idx == len_q - 1'b1);
  assign rd_big  = |acc_rdata[REG_DW-1:8];
  assign rd_bad  = (acc_rdata[7:0] != img_byte);

  always_comb begin
    acc_addr  = DATA_REG;
    acc_wdata = '0;
    case (st)
      S_HOLD:          begin acc_addr = CTRL_REG; acc_wdata = HOLD_WORD; end
      S_REW1, S_REW2:  acc_addr = PTR_REG;
      S_LOAD:          acc_wdata = {{(REG_DW-8){1'b0}}, img_byte};
      S_RUN:           begin acc_addr = CTRL_REG; acc_wdata = RUN_WORD; end
      default:         ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; len_q <= '0;
      miss_cnt <= '0; first_miss <= '0; done <= 1'b0; pass <= 1'b0;
    end else if (st == S_IDLE) begin
      if (go) begin
        st <= S_HOLD; len_q <= img_len; idx <= '0;
        miss_cnt <= '0; first_miss <= '0; done <= 1'b0; pass <= 1'b0;
      end
    end else if (acc_ack) begin
      if (acc_err) begin
        st <= S_IDLE; done <= 1'b1; pass <= 1'b0;
      end else begin
        case (st)
          S_HOLD: st <= S_REW1;
          S_REW1: st <= (len_q == '0) ? S_REW2 : S_LOAD;
          S_LOAD: begin
            if (last) begin idx <= '0; st <= S_REW2; end
            else idx <= idx + 1'b1;
          end
          S_REW2: st <= (len_q == '0) ? S_RUN : S_CHECK;
          S_CHECK: begin
            if (rd_big) begin
              st <= S_IDLE; done <= 1'b1;
            end else begin
              if (rd_bad) begin
                miss_cnt <= miss_cnt + 1'b1;
                if (miss_cnt == '0) first_miss <= idx;
              end
              if ((rd_bad && miss_cnt == MW'(MISS_LIMIT)) || (last && (rd_bad || miss_cnt != '0))) begin
                st <= S_IDLE; done <= 1'b1;
              end else if (last) st <= S_RUN;
              else idx <= idx + 1'b1;
            end
          end
          S_RUN: begin st <= S_IDLE; done <= 1'b1; pass <= 1'b1; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_we) && $stable(acc_wdata));

  assert_miss_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt <= MW'(MISS_LIMIT + 1));

  assert_err_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack && acc_err |=> done && !pass && !acc_req && $stable(miss_cnt));

  assert_big_fatal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_we && acc_ack && !acc_err && rd_big |=> done && !pass && !acc_req);

  assert_pass_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && miss_cnt == '0);

  assert_run_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_we && acc_addr == CTRL_REG && acc_wdata == RUN_WORD |-> miss_cnt == '0);

endmodule

// File: tb/ucode_loader_test.sv
module ucode_loader_test;
  localparam int LW = 12;

  logic clk = 0, rst_n = 0, go = 0;
  logic [LW-1:0] img_len = '0, img_idx, first_miss;
  logic [7:0] img_byte;
  logic acc_req, acc_we, acc_ack = 0, acc_err = 0;
  logic [7:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata = '0;
  logic busy, done, pass;
  logic [2:0] miss_cnt;

  always #5 clk = ~clk;

  assign img_byte = 8'(img_idx[7:0] * 8'd7 + 8'd3);

  ucode_loader uut (.clk(clk), .rst_n(rst_n), .go(go), .img_len(img_len), .img_idx(img_idx),
    .img_byte(img_byte), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .busy(busy), .done(done), .pass(pass), .miss_cnt(miss_cnt), .first_miss(first_miss));

  int checks = 0, fails = 0, cyc = 0;

  // slave model configuration
  int cur_clo = -1, cur_chi = -1, cur_big = -1, cur_erra = -1, cur_lat = 0;
  logic [7:0] mem [256];
  logic [7:0] ptr = 0;
  int ntx = 0, wcnt = 0, viol = 0;
  logic hold = 0;
  logic [7:0] h_addr; logic h_we; logic [31:0] h_wd;
  logic        log_we [32];
  logic [7:0]  log_addr [32];
  logic [31:0] log_wd [32];

  always @(negedge clk) begin
    if (!rst_n) begin
      acc_ack = 0; acc_err = 0; wcnt = 0; hold = 0;
    end else if (acc_ack) begin
      acc_ack = 0; acc_err = 0; wcnt = 0; hold = 0;
    end else if (acc_req) begin
      if (!hold) begin
        hold = 1; h_addr = acc_addr; h_we = acc_we; h_wd = acc_wdata;
      end else if (acc_addr != h_addr || acc_we != h_we || acc_wdata != h_wd) viol++;
      if (wcnt >= cur_lat) begin
        if (ntx < 32) begin log_we[ntx] = acc_we; log_addr[ntx] = acc_addr; log_wd[ntx] = acc_wdata; end
        acc_err = (ntx == cur_erra);
        acc_rdata = '0;
        if (acc_we) begin
          if (acc_addr == 8'h11) ptr = acc_wdata[7:0];
          if (acc_addr == 8'h12) begin mem[ptr] = acc_wdata[7:0]; ptr++; end
        end else if (acc_addr == 8'h12) begin
          acc_rdata = {24'd0, mem[ptr]};
          if (int'(ptr) >= cur_clo && int'(ptr) < cur_chi) acc_rdata[7:0] ^= 8'h5A;
          if (int'(ptr) == cur_big) acc_rdata[8] = 1'b1;
          ptr++;
        end
        ntx++;
        acc_ack = 1;
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // expected access k for an image of len bytes: {we, addr, wdata}
  function automatic logic [40:0] exp_tx(input int k, input int len);
    if (k == 0) return {1'b1, 8'h10, 32'h8C};
    if (k == 1 || k == len + 2) return {1'b1, 8'h11, 32'h0};
    if (k < len + 2) return {1'b1, 8'h12, 24'd0, 8'((k - 2) * 7 + 3)};
    if (k < 2 * len + 3) return {1'b0, 8'h12, 32'h0};
    return {1'b1, 8'h10, 32'h10B};
  endfunction

  task automatic run(input int len, input int clo, input int chi, input int big, input int erra, input int lat);
    cur_clo = clo; cur_chi = chi; cur_big = big; cur_erra = erra; cur_lat = lat; ntx = 0;
    img_len = LW'(len); go = 1;
    @(negedge clk); go = 0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  task automatic seq_check(input int len, input string tag);
    int bad = 0;
    for (int k = 0; k < ntx && k < 32; k++) begin
      logic [40:0] e = exp_tx(k, len);
      if (log_we[k] != e[40] || log_addr[k] != e[39:32] || (e[40] && log_wd[k] != e[31:0])) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  typedef struct packed {
    int len; int clo; int chi; int big; int erra; int lat;
    int xp; int xmiss; int xfirst; int xtx;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8,  -1, -1, -1, -1, 0,  1, 0, 0, 20},
    '{8,   3,  4, -1, -1, 1,  0, 1, 3, 19},
    '{10,  2, 12, -1, -1, 0,  0, 5, 2, 20},
    '{10,  5,  9, -1, -1, 2,  0, 4, 5, 23},
    '{6,  -1, -1,  2, -1, 0,  0, 0, 0, 12},
    '{6,  -1, -1, -1,  4, 1,  0, 0, 0, 5},
    '{0,  -1, -1, -1, -1, 0,  1, 0, 0, 4},
    '{1,  -1, -1, -1, -1, 3,  1, 0, 0, 6},
    '{3,  -1, -1, -1,  9, 0,  0, 0, 0, 10},
    '{5,   0,  5, -1, -1, 0,  0, 5, 0, 13},
    '{4,   0,  4, -1,  8, 0,  0, 1, 0, 9}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !pass && !busy && !acc_req, "R1 flags", {done, pass, busy, acc_req}, 0);
    chk(miss_cnt == 0 && first_miss == 0, "R1 counters", miss_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!acc_req && !done, "R1 idle after release", acc_req, 0);

    foreach (VECS[r]) begin
      vec_t v = VECS[r];
      run(v.len, v.clo, v.chi, v.big, v.erra, v.lat);
      chk(done == 1, $sformatf("row%0d done R6 R11", r), done, 1);
      chk(pass == v.xp[0], $sformatf("row%0d pass R9 R10 R12", r), pass, v.xp);
      chk(int'(miss_cnt) == v.xmiss, $sformatf("row%0d miss R7 R8", r), miss_cnt, v.xmiss);
      chk(int'(first_miss) == v.xfirst, $sformatf("row%0d first R7", r), first_miss, v.xfirst);
      chk(ntx == v.xtx, $sformatf("row%0d access count R6 R8 R11", r), ntx, v.xtx);
      seq_check(v.len, $sformatf("row%0d order R2 R3 R4 R5", r));
      @(negedge clk);
      chk(!acc_req, $sformatf("row%0d quiet after end R6", r), acc_req, 0);
    end

    // R14: go during a run with another length is ignored
    cur_clo = -1; cur_chi = -1; cur_big = -1; cur_erra = -1; cur_lat = 0; ntx = 0;
    img_len = 12'd4; go = 1; @(negedge clk); go = 0;
    repeat (4) @(negedge clk);
    img_len = 12'd9; go = 1; @(negedge clk); go = 0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    chk(ntx == 12 && pass, "R14 go ignored while busy", ntx, 12);
    seq_check(4, "R14 sequence kept");

    // R13 request stability seen by the slave across all runs
    chk(viol == 0, "R13 request held until ack", viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule